// File: doc/BRIEF.md
# Mask-Indexed GPIO Bank Register Block

This block holds the control state for a bank of 32 general-purpose I/O lines and exposes it on a plain memory-mapped register bus. The bus has an address, a write enable, write data and read data. Reads are combinational from the address, and writes take effect at the clock edge. Each line owns one configuration word. The configuration words are not mapped one per address. Software first loads a line-select mask, and a single shared configuration window then reaches the words of the selected lines.

A window write updates every selected line at once, so a group of lines can be configured in one access. A window read returns the word of the lowest-numbered selected line. Output data has three addresses: one sets bits, one clears bits, and one reads the current value back. The pad input levels are synchronized and can be read as one word. Toward the pads the block drives, for every line, the output value, the output enable and the function select. Pad electrical behaviour and interrupt detection are handled elsewhere.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted, and right after it, the mask, the output data and every configuration word are zero. Consequently `out_val_o`, `out_en_o` and `func_sel_o` are all zero.
- R2: A write to offset 0x00 loads the line-select mask, where bit n selects line n. A read of 0x00 returns the mask. The mask changes only when 0x00 is written.
- R3: A write to the window at offset 0x04 stores the write data into every line whose mask bit is set, and leaves the other lines unchanged. Only the defined fields are kept: function bits 2:0, direction bit 8, pull-up bit 9, pull-down bit 10, filter enable bit 12, slow filter clock bit 13, open-drain bit 14, Schmitt bit 15 and event select bits 26:24 (writable mask 0x0700F707). Every other bit reads back as 0.
- R4: A read of offset 0x04 returns the configuration word of the lowest-numbered line selected by the mask. It returns 0 when the mask is empty.
- R5: A write to offset 0x10 sets to 1 the output data bit of every line whose write-data bit is 1. Lines with a 0 bit keep their value. A read of 0x10 returns 0.
- R6: A write to offset 0x14 clears to 0 the output data bit of every line whose write-data bit is 1. Lines with a 0 bit keep their value. A read of 0x14 returns 0.
- R7: A read of offset 0x18 returns the output data register, and `out_val_o` carries the same value.
- R8: A read of offset 0x08 returns the pad input levels through a two-flop synchronizer. A level present before a clock edge becomes visible after the second edge.
- R9: `func_sel_o[3n+2:3n]` equals bits 2:0 of line n's configuration word. Value 0 means plain GPIO and values 1 to 7 select peripheral functions A to G.
- R10: `out_en_o[n]` is line n's direction bit (bit 8, where 1 means output). It is forced to 0 while open-drain (bit 14) is set and line n's output data is 1.
- R11: Any other offset reads as 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address (combinational) |
| pad_in_i | input | 32 | Raw pad input levels |
| out_val_o | output | 32 | Output value for each line |
| out_en_o | output | 32 | Output enable for each line |
| func_sel_o | output | 96 | Function select for each line, 3 bits per line |

## Verification
Two functions can act in the same cycle. An output-data write changes a line's value, and the open-drain gating of that line's enable reacts to the new value. Both take effect on the same clock edge. The bench provokes this by setting and clearing output bits on lines configured as open-drain outputs, in a directed sequence and then in a long random run. A behavioural reference model predicts the value and the enable for every line each cycle, and any cycle where the enable leads or lags the value counts as a mismatch. Multi-line window writes followed by reads under overlapping masks also exercise the lowest-line pick against the group write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned CFG_W  = 32;

  localparam logic [REG_AW-1:0] OFS_MASK = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CFG  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_PIN  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_SET  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CLR  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_OUT  = 8'h18;

  // configuration word field positions (software-visible layout)
  localparam int unsigned FN_LSB    = 0;
  localparam int unsigned FN_W      = 3;
  localparam int unsigned DIR_BIT   = 8;
  localparam int unsigned PU_BIT    = 9;
  localparam int unsigned PD_BIT    = 10;
  localparam int unsigned FLT_BIT   = 12;
  localparam int unsigned FSLOW_BIT = 13;
  localparam int unsigned OD_BIT    = 14;
  localparam int unsigned SCH_BIT   = 15;
  localparam int unsigned EVT_LSB   = 24;
  localparam int unsigned EVT_W     = 3;

  localparam logic [CFG_W-1:0] CFG_WMASK =
      (CFG_W'((1 << FN_W) - 1) << FN_LSB) |
      (CFG_W'(1) << DIR_BIT) | (CFG_W'(1) << PU_BIT) | (CFG_W'(1) << PD_BIT) |
      (CFG_W'(1) << FLT_BIT) | (CFG_W'(1) << FSLOW_BIT) |
      (CFG_W'(1) << OD_BIT)  | (CFG_W'(1) << SCH_BIT) |
      (CFG_W'((1 << EVT_W) - 1) << EVT_LSB);

  typedef enum logic [2:0] {
    REG_NONE, REG_MASK, REG_CFG, REG_PIN, REG_SET, REG_CLR, REG_OUT
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_MASK: s = REG_MASK;
      OFS_CFG:  s = REG_CFG;
      OFS_PIN:  s = REG_PIN;
      OFS_SET:  s = REG_SET;
      OFS_CLR:  s = REG_CLR;
      OFS_OUT:  s = REG_OUT;
      default:  s = REG_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [NUM_LINES-1:0] sel_i,
  input  logic [CFG_W-1:0]     wdata_i,
  output logic [CFG_W-1:0]     cfg_o [NUM_LINES],
  output logic [CFG_W-1:0]     rd_word_o
);

  logic [CFG_W-1:0] cfg_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cfg_q[g] <= '0;
      else if (wr_i && sel_i[g])  cfg_q[g] <= wdata_i & CFG_WMASK;
    end
    assign cfg_o[g] = cfg_q[g];

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && sel_i[g]) |=> $stable(cfg_q[g])); // R3
    AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && sel_i[g]) |=> (rd_word_o == cfg_q[g]) || !sel_i[g] ||
                             ((sel_i & ((NUM_LINES'(1) << g) - 1'b1)) != '0)); // R4
  end

  // lowest selected line wins
  always_comb begin
    rd_word_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (sel_i[i]) rd_word_o = cfg_q[i];
    end
  end

  AST_EMPTY_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> (rd_word_o == '0)); // R4

endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_we_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] bits_i,
  output logic [NUM_LINES-1:0] out_q_o
);

  logic [NUM_LINES-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (set_we_i) out_q <= out_q | bits_i;
    else if (clr_we_i) out_q <= out_q & ~bits_i;
  end

  assign out_q_o = out_q;

  AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((out_q & $past(bits_i)) == $past(bits_i)) &&
                 ((out_q & ~$past(bits_i)) == ($past(out_q) & ~$past(bits_i)))); // R5
  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((out_q & $past(bits_i)) == '0) &&
                 ((out_q & ~$past(bits_i)) == ($past(out_q) & ~$past(bits_i)))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_we_i || clr_we_i) |=> $stable(out_q)); // R7

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pad_i,
  output logic [NUM_LINES-1:0] level_o
);

  logic [NUM_LINES-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
    end
  end

  assign level_o = sync_q;

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (level_o == $past(pad_i, 2))); // R8

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [CFG_W-1:0]          cfg_i [NUM_LINES],
  input  logic [NUM_LINES-1:0]      out_val_i,
  output logic [NUM_LINES-1:0]      out_en_o,
  output logic [NUM_LINES*FN_W-1:0] func_sel_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pad
    // open-drain: release the pad instead of driving a 1
    assign out_en_o[g] = cfg_i[g][DIR_BIT] & ~(cfg_i[g][OD_BIT] & out_val_i[g]);
    assign func_sel_o[g*FN_W +: FN_W] = cfg_i[g][FN_LSB +: FN_W];
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [REG_AW-1:0]         addr_i,
  input  logic                      wr_en_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NUM_LINES-1:0]      pad_in_i,
  output logic [NUM_LINES-1:0]      out_val_o,
  output logic [NUM_LINES-1:0]      out_en_o,
  output logic [NUM_LINES*FN_W-1:0] func_sel_o
);

  localparam int unsigned DW = 32;

  reg_sel_e sel;
  logic mask_we, cfg_we, set_we, clr_we;
  logic [NUM_LINES-1:0] mask_q, out_q, pin_lvl;
  logic [CFG_W-1:0] cfg_w [NUM_LINES];
  logic [CFG_W-1:0] cfg_rd;

  assign sel     = decode_ofs(addr_i);
  assign mask_we = wr_en_i && (sel == REG_MASK);
  assign cfg_we  = wr_en_i && (sel == REG_CFG);
  assign set_we  = wr_en_i && (sel == REG_SET);
  assign clr_we  = wr_en_i && (sel == REG_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= wdata_i[NUM_LINES-1:0];
  end

  gpio_cfg_store #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_we),
    .sel_i     (mask_q),
    .wdata_i   (wdata_i),
    .cfg_o     (cfg_w),
    .rd_word_o (cfg_rd)
  );

  gpio_out_data #(.NUM_LINES(NUM_LINES)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .clr_we_i (clr_we),
    .bits_i   (wdata_i[NUM_LINES-1:0]),
    .out_q_o  (out_q)
  );

  gpio_in_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pad_i   (pad_in_i),
    .level_o (pin_lvl)
  );

  gpio_pad_drive #(.NUM_LINES(NUM_LINES)) u_drv (
    .cfg_i      (cfg_w),
    .out_val_i  (out_q),
    .out_en_o   (out_en_o),
    .func_sel_o (func_sel_o)
  );

  assign out_val_o = out_q;

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_MASK: rdata_o = DW'(mask_q);
      REG_CFG:  rdata_o = cfg_rd;
      REG_PIN:  rdata_o = DW'(pin_lvl);
      REG_OUT:  rdata_o = DW'(out_q);
      default:  rdata_o = '0;
    endcase
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we |=> $stable(mask_q)); // R2
  AST_OE_DIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we && !wdata_i[DIR_BIT]) |=> ((out_en_o & $past(mask_q)) == '0)); // R10
  AST_OD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we |=> ((out_en_o & $past(wdata_i[NUM_LINES-1:0]) & od_vec) == '0)); // R10
  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel == REG_SET) || (sel == REG_CLR)) |-> (rdata_o == '0)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == REG_NONE) |-> (rdata_o == '0)); // R11

  logic [NUM_LINES-1:0] od_vec;
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    assign od_vec[g] = cfg_w[g][OD_BIT];
    AST_FUNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we && mask_q[g]) |=> (func_sel_o[g*FN_W +: FN_W] == $past(wdata_i[FN_W-1:0]))); // R9
  end

endmodule

// File: tb/gpio_bank_regs_bench.sv
`timescale 1ns/1ps
module gpio_bank_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pad = '0;
  logic [31:0] rdata, out_val, out_en;
  logic [95:0] func_sel;

  always #2.5 clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .pad_in_i   (pad),
    .out_val_o  (out_val),
    .out_en_o   (out_en),
    .func_sel_o (func_sel)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  // reference model state
  logic [31:0] m_cfg [32];
  logic [31:0] m_mask, m_out, m_s1, m_s2;
  logic [7:0]  picks [8] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h0C, 8'h1C};

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_cfg[i] = '0;
      m_mask = '0; m_out = '0; m_s1 = '0; m_s2 = '0;
    end else begin
      if (wr_en) begin
        case (addr)
          8'h00: m_mask = wdata;
          8'h04: for (int i = 0; i < 32; i++) if (m_mask[i]) m_cfg[i] = wdata & 32'h0700_F707;
          8'h10: m_out = m_out | wdata;
          8'h14: m_out = m_out & ~wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pad;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      8'h00: r = m_mask;
      8'h04: begin
        for (int i = 31; i >= 0; i--) if (m_mask[i]) r = m_cfg[i];
      end
      8'h08: r = m_s2;
      8'h18: r = m_out;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R2 mask read";
      8'h04: return "R4 window read";
      8'h08: return "R8 pin level read";
      8'h10: return "R5 set reg read";
      8'h14: return "R6 clear reg read";
      8'h18: return "R7 out data read";
      default: return "R11 unmapped read";
    endcase
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] e;
    for (int i = 0; i < 32; i++) e[i] = m_cfg[i][8] & ~(m_cfg[i][14] & m_out[i]);
    return e;
  endfunction

  function automatic logic [95:0] exp_fn();
    logic [95:0] f;
    for (int i = 0; i < 32; i++) f[i*3 +: 3] = m_cfg[i][2:0];
    return f;
  endfunction

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #2;
    if (cmp_on && rst_n) begin
      chk("R7 out_val", 96'(out_val), 96'(m_out));
      chk("R10 out_en", 96'(out_en), 96'(exp_oe()));
      chk("R9 func_sel", func_sel, exp_fn());
      chk(rd_tag(addr), 96'(rdata), 96'(exp_rd(addr)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    chk(req, 96'(rdata), 96'(e));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    #12;
    chk("R1 reset out_val", 96'(out_val), 96'h0);
    chk("R1 reset out_en", 96'(out_en), 96'h0);
    chk("R1 reset func_sel", func_sel, 96'h0);
    chk("R1 reset mask", 96'(rdata), 96'h0);
    addr = 8'h18; #1;
    chk("R1 reset out data", 96'(rdata), 96'h0);
    addr = 8'h04; #1;
    chk("R1 reset window", 96'(rdata), 96'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // group write to lines 0 and 2
    wr(8'h00, 32'h0000_0005);
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R3 defined bits only", 96'(rdata), 96'h0700_F707);
    chk("R9 func lines 0 and 2", 96'(func_sel[8:0]), 96'h1C7);
    chk("R10 oe on lines 0 and 2", 96'(out_en), 96'h5);
    expect_rd(8'h04, 32'h0700_F707, "R3 window after group write");
    wr(8'h00, 32'h0000_0002);
    expect_rd(8'h04, 32'h0, "R3 unselected line untouched");
    wr(8'h00, 32'h0000_0006);
    expect_rd(8'h04, 32'h0, "R4 lowest line 1 wins");
    wr(8'h00, 32'h0000_0004);
    expect_rd(8'h04, 32'h0700_F707, "R4 single line 2");
    wr(8'h00, 32'h0);
    expect_rd(8'h04, 32'h0, "R4 empty mask");
    expect_rd(8'h00, 32'h0, "R2 mask cleared");

    wr(8'h00, 32'h8000_0000);
    wr(8'h04, 32'h0000_0103);
    expect_rd(8'h00, 32'h8000_0000, "R2 mask readback");
    expect_rd(8'h04, 32'h0000_0103, "R3 line 31 word");

    // open-drain gating together with set/clear
    wr(8'h10, 32'h8000_0005);
    chk("R10 open-drain release", 96'(out_en), 96'h8000_0000);
    expect_rd(8'h18, 32'h8000_0005, "R7 after set");
    expect_rd(8'h10, 32'h0, "R5 set reg reads zero");
    wr(8'h14, 32'h0000_0004);
    chk("R6 clear line 2", 96'(out_val), 96'h8000_0001);
    chk("R10 open-drain drives low", 96'(out_en), 96'h8000_0004);
    expect_rd(8'h14, 32'h0, "R6 clear reg reads zero");

    // unmapped offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0);
    expect_rd(8'h0C, 32'h0, "R11 unmapped reads zero");
    expect_rd(8'h18, 32'h8000_0001, "R11 out data unchanged");
    expect_rd(8'h00, 32'h8000_0000, "R11 mask unchanged");

    // synchronizer latency
    @(negedge clk);
    addr = 8'h08; pad = 32'hA5A5_0F0F;
    @(posedge clk); #2;
    chk("R8 not yet visible", 96'(rdata), 96'h0);
    @(posedge clk); #2;
    chk("R8 visible after two edges", 96'(rdata), 96'hA5A5_0F0F);

    // random traffic
    repeat (600) begin
      @(negedge clk);
      addr  = picks[$urandom_range(0, 7)];
      wr_en = 1'($urandom_range(0, 1));
      wdata = $urandom();
      pad   = $urandom();
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule